// File: doc/BRIEF.md
# Processor Tick Timer

This block is a free-running tick timer with an interrupt, meant to sit beside a processor core. It holds two 32-bit registers. The control register carries a period, an interrupt-enable bit, a sticky interrupt-pending bit and a two-bit mode. The count register advances by one on every `tick` pulse while the timer runs. A single-cycle write port sets either register. A combinational read port returns either register exactly as stored.

A match happens when the low `PERIOD_W` bits of the count equal the period field. The check is made on a tick cycle while the timer runs, using the count as it stands before that tick. The mode decides what the match does: clear the count and carry on, stop the timer, or keep counting and wrap through the period bits. If interrupt-enable is set, a match also raises the pending flag. A registered copy of that flag drives `irq` until software clears it.

A control write never sets the pending flag itself. Writing that bit as one keeps the flag as it is, and writing it as zero clears it. This lets software rewrite the period or mode without losing an interrupt that has not yet been serviced.

Top module: `tick_timer`

## Requirements
- R1: After reset the control register, the count register and `irq` are all zero, and the timer is not running.
- R2: Mode is control bits 31:30, with 00 = disabled, 01 = restart, 10 = one-shot and 11 = continuous. While the mode is 00, `tick` pulses leave the count unchanged.
- R3: While running, each cycle with `tick` high adds one to the count. A cycle without `tick` leaves the count unchanged.
- R4: A match is a running tick cycle in which count bits PERIOD_W-1:0 equal control bits PERIOD_W-1:0. Count bits above PERIOD_W-1 take no part in the match.
- R5: On a match, the pending bit (control bit 28) is set if interrupt-enable (control bit 29) is one. It is left unchanged if interrupt-enable is zero.
- R6: On a match in restart mode, the count becomes zero and the timer keeps running.
- R7: On a match in one-shot mode, the count holds its value and the timer stops. It stays stopped until a control write with a nonzero mode or a count write while the mode is nonzero.
- R8: On a match in continuous mode, the count increments as usual, wraps at 2^32, and keeps running.
- R9: A control write stores all bits except bit 28 as written. Bit 28 written as 1 keeps the pending bit, and a match in the same cycle can still set it. Bit 28 written as 0 clears the pending bit. A written mode of 00 stops the timer, and any other mode starts it.
- R10: A count write loads the written value. The timer then runs if the current mode is nonzero and stops if it is 00.
- R11: `irq` equals the pending bit as it stood one cycle earlier.
- R12: When a write and a match fall in the same cycle, the written register takes the written value (subject to R9 for bit 28). The match is judged on the count before the write.
- R13: `rd_data` shows the control register when `rd_sel` is 0 and the count register when `rd_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 count |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read select: 0 control, 1 count |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Timer interrupt |

## Verification
The bench builds the timer with `PERIOD_W` = 4, so the period compare spans only sixteen values. Random period and count writes then land on matches every few dozen ticks, and all four modes fire many times within a short run. Count writes carry random upper bits, which tests that the match ignores them. Directed cases also place a match in the same cycle as a count write or a pending-bit clear.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int PERIOD_W = 28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  output logic        irq
);
  localparam int IP_BIT = 28;
  localparam int IE_BIT = 29;
  localparam logic [1:0] M_OFF = 2'b00, M_RESTART = 2'b01, M_ONESHOT = 2'b10;

  logic [31:0] ctrl_q, cnt_q, ctrl_d, cnt_d;
  logic        run_q, run_d;

  wire [1:0] mode    = ctrl_q[31:30];
  wire       hit     = run_q & tick & (cnt_q[PERIOD_W-1:0] == ctrl_q[PERIOD_W-1:0]);
  wire       ip_now  = ctrl_q[IP_BIT] | (hit & ctrl_q[IE_BIT]);
  wire       ctrl_wr = wr_en & ~wr_sel;
  wire       cnt_wr  = wr_en & wr_sel;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    ctrl_d = ctrl_q;
    ctrl_d[IP_BIT] = ip_now;
    if (run_q && tick) begin
      if (hit && mode == M_RESTART)      cnt_d = '0;
      else if (hit && mode == M_ONESHOT) run_d = 1'b0;
      else                               cnt_d = cnt_q + 32'd1;
    end
    if (ctrl_wr) begin
      ctrl_d = wr_data;
      ctrl_d[IP_BIT] = wr_data[IP_BIT] & ip_now;
      run_d = (wr_data[31:30] != M_OFF);
    end
    if (cnt_wr) begin
      cnt_d = wr_data;
      run_d = (mode != M_OFF);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      irq    <= ctrl_q[IP_BIT];
    end
  end

  assign rd_data = rd_sel ? cnt_q : ctrl_q;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int PERIOD_W = 28
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [31:0] wr_data,
  input logic        irq,
  input logic [31:0] ctrl_q,
  input logic [31:0] cnt_q,
  input logic        run_q
);
  wire match = run_q & tick & (cnt_q[PERIOD_W-1:0] == ctrl_q[PERIOD_W-1:0]);
  wire cwr   = wr_en & ~wr_sel;
  wire nwr   = wr_en & wr_sel;

  AST_IRQ_LAGS_IP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> irq == $past(ctrl_q[28])); // R11
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q[31:30] == 2'b00 && !nwr) |=> $stable(cnt_q)); // R2
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (match && ctrl_q[31:30] == 2'b01 && !nwr) |=> cnt_q == 32'd0); // R6
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n) (match && ctrl_q[31:30] == 2'b10 && !wr_en) |=> ($stable(cnt_q) && !run_q)); // R7
  AST_IP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (cwr && !wr_data[28]) |=> !ctrl_q[28]); // R9
  AST_COUNT_LOADS: assert property (@(posedge clk) disable iff (!rst_n) nwr |=> cnt_q == $past(wr_data)); // R10
  AST_IP_SETS: assert property (@(posedge clk) disable iff (!rst_n) (match && ctrl_q[29] && !(cwr && !wr_data[28])) |=> ctrl_q[28]); // R5
endmodule

bind tick_timer tick_timer_chk #(.PERIOD_W(PERIOD_W)) u_chk (.*);

// File: tb/test_tick_timer.sv
`timescale 1ns/100ps
module test_tick_timer;
  localparam int PW = 4;
  localparam logic [31:0] MASK = (32'd1 << PW) - 32'd1;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq;
  int checks = 0, fails = 0;

  logic [31:0] m_ctrl = '0, m_cnt = '0;
  logic m_run = 0, m_irq = 0;

  tick_timer #(.PERIOD_W(PW)) i_tick_timer (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    #0.5 rd_sel = 0;
    #0.5 chk(tag, "ctrl(R13)", rd_data, m_ctrl);
    chk(tag, "irq(R11)", {31'd0, irq}, {31'd0, m_irq});
    rd_sel = 1;
    #0.5 chk(tag, "count(R13)", rd_data, m_cnt);
  endtask

  function automatic void step(input bit tk, input bit we, input bit sel, input logic [31:0] wd);
    logic [31:0] n_ctrl = m_ctrl, n_cnt = m_cnt;
    logic n_run = m_run;
    logic [1:0] md = m_ctrl[31:30];
    bit hit = m_run && tk && ((m_cnt & MASK) == (m_ctrl & MASK));
    logic ip = m_ctrl[28] | (hit & m_ctrl[29]);
    if (m_run && tk) begin
      if (hit && md == 2'b01) n_cnt = 0;
      else if (hit && md == 2'b10) n_run = 0;
      else n_cnt = m_cnt + 1;
    end
    n_ctrl[28] = ip;
    if (we && !sel) begin
      n_ctrl = wd;
      n_ctrl[28] = wd[28] & ip;
      n_run = wd[31:30] != 2'b00;
    end
    if (we && sel) begin
      n_cnt = wd;
      n_run = md != 2'b00;
    end
    m_irq = m_ctrl[28];
    m_ctrl = n_ctrl; m_cnt = n_cnt; m_run = n_run;
  endfunction

  task automatic cyc(input string tag, input bit tk, input bit we, input bit sel, input logic [31:0] wd);
    @(negedge clk);
    tick = tk; wr_en = we; wr_sel = sel; wr_data = wd;
    step(tk, we, sel, wd);
    @(posedge clk);
    compare(tag);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    compare("R1");
    @(negedge clk) rst_n = 1;
    // disabled mode: count write loads, ticks ignored
    cyc("R10", 0, 1, 1, 32'd5);
    repeat (3) cyc("R2", 1, 0, 0, 0);
    // restart mode with IE, period 3
    cyc("R9", 0, 1, 0, 32'h6000_0003);
    cyc("R10", 0, 1, 1, 32'd0);
    repeat (3) cyc("R3", 1, 0, 0, 0);
    cyc("R6", 1, 0, 0, 0);
    cyc("R5", 0, 0, 0, 0);
    cyc("R11", 0, 0, 0, 0);
    // keep then clear pending
    cyc("R9", 0, 1, 0, 32'h7000_0003);
    cyc("R9", 1, 1, 0, 32'h6000_0003);
    cyc("R11", 0, 0, 0, 0);
    // one-shot, IE off, period 2
    cyc("R9", 0, 1, 0, 32'h8000_0002);
    cyc("R10", 0, 1, 1, 32'd0);
    repeat (6) cyc("R7", 1, 0, 0, 0);
    // continuous, upper count bits ignored in match
    cyc("R9", 0, 1, 0, 32'hE000_0002);
    cyc("R4", 0, 1, 1, 32'hFFFF_FFF1);
    repeat (20) cyc("R8", 1, 0, 0, 0);
    // count write in the same cycle as a match
    cyc("R9", 0, 1, 0, 32'h6000_0004);
    cyc("R10", 0, 1, 1, 32'h0000_0024);
    cyc("R12", 1, 1, 1, 32'd9);
    cyc("R12", 1, 0, 0, 0);
    // clear pending in the same cycle as a match
    cyc("R10", 0, 1, 1, 32'd4);
    cyc("R12", 1, 1, 0, 32'h6000_0004);
    cyc("R11", 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 63);
      logic [31:0] d = $urandom;
      if (r == 0) cyc("R9", $urandom_range(0,1), 1, 0, {d[31:28], 24'd0, d[PW-1:0]} | (d[3] ? 32'h1000_0000 : 0));
      else if (r == 1) cyc("R10", $urandom_range(0,1), 1, 1, d);
      else if (r == 2) cyc("R9", 0, 1, 0, d);
      else cyc("R3", $urandom_range(0,3) != 0, 0, 0, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule